// File: doc/BRIEF.md
# Conditional Branch Resolve Unit

This block resolves the control flow of one branch instruction from a compact 32-bit core that uses byte-wide opcodes. It is given up to three instruction bytes, the zero, negative, carry and overflow flags, the address of the instruction, and the loop address register. It returns whether the branch is taken, the next program counter, the instruction length in bytes, the execution cycle count, and a flag that is raised when the bytes do not form a branch. It never changes the flags. Fetching instructions, updating flags and writing the loop register are handled elsewhere.

Three encoding families are recognised. The short family is two bytes long: the condition sits in the low nibble of the first byte, and the second byte is a signed displacement. The prefixed family is three bytes long: it starts with 0xF8, the second byte selects an overflow test or a sign test, and the third byte is the displacement. The loop family is one byte long. A taken loop branch jumps to the loop register minus four. All other branches jump relative to their own address.

Requests arrive on a valid/ready input and results leave on a valid/ready output, with one register stage between them. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. The result appears one clock after acceptance. It stays unchanged until `out_ready` is seen high.

Top module: `br_resolve`

## Requirements
- R1: When byte0 is 0xC0 to 0xC9, the instruction is a two-byte conditional branch and the low nibble selects the condition: 0 less (N^V), 1 greater (!(Z|(N^V))), 2 greater-or-equal (!(N^V)), 3 less-or-equal (Z|(N^V)), 4 carry set (C), 5 higher (!(C|Z)), 6 carry clear (!C), 7 lower-or-same (C|Z), 8 equal (Z), 9 not-equal (!Z).
- R2: When byte0 is 0xF8 and byte1 is 0xE8, 0xE9, 0xEA or 0xEB, the instruction is a three-byte branch. It is taken on V=0, V=1, N=0 or N=1 respectively, and byte2 is the displacement.
- R3: A taken relative branch gives next PC = instruction address + sign-extended 8-bit displacement, modulo 2^32.
- R4: A relative branch that is not taken gives next PC = address + length, where the length is 2 for the short form and 3 for the prefixed form. `out_len` reports that length in every case.
- R5: Byte0 = 0xCA is an unconditional two-byte branch. It is always taken and reports 3 cycles.
- R6: Byte0 = 0xD8 is taken when Z=1 and byte0 = 0xD9 is taken when Z=0. When taken, next PC = loop register − 4 (modulo 2^32); otherwise next PC = address + 1. The length is 1 and the cycle count is 1 when taken and 2 when not.
- R7: The cycle count is 3 (taken) or 1 (not taken) for conditional short branches, and 4 or 2 for prefixed branches.
- R8: Any other byte pattern, including 0xCB to 0xCF and 0xF8 followed by a byte outside 0xE8 to 0xEB, sets `out_not_branch`. In that case taken is 0, next PC = address + 1, length is 1 and cycles is 0.
- R9: A request accepted at one clock edge appears at the next edge with `out_valid` high. `in_ready` = !out_valid | out_ready. While out_valid is high and out_ready is low, every output holds its value and new requests are refused.
- R10: A synchronous active-high reset clears out_valid and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_byte0 | input | 8 | First instruction byte |
| in_byte1 | input | 8 | Second instruction byte |
| in_byte2 | input | 8 | Third instruction byte |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| cur_pc | input | 32 | Address of the instruction |
| loop_addr | input | 32 | Loop address register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Resolved next PC |
| out_len | output | 2 | Instruction length in bytes |
| out_cycles | output | 3 | Execution cycle count |
| out_not_branch | output | 1 | Bytes are not a recognised branch |

## Verification
The hardest situation to reach from the ports is a held result under back-pressure. A second, different request must be waiting at the input while the first result sits unread. The bench drops out_ready, sends one branch, then offers a different one for several cycles. It checks that in_ready stays low and that the first result does not change. It then releases out_ready and expects the second result. The address-wrap corners are also covered: a displacement that crosses zero in each direction, and a loop register below four.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int PC_W   = 32;
  localparam int DISP_W = 8;
  localparam int LEN_W  = 2;
  localparam int CYC_W  = 3;

  typedef enum logic [1:0] {K_NONE, K_REL, K_LOOP} kind_t;

  typedef enum logic [3:0] {
    C_ALW, C_EQ, C_NE, C_GT, C_GE, C_LE, C_LT, C_HI,
    C_CC,  C_LS, C_CS, C_VC, C_VS, C_NC, C_NS, C_NEV
  } cond_t;

  typedef struct packed {
    kind_t             kind;
    cond_t             cond;
    logic [DISP_W-1:0] disp;
    logic [LEN_W-1:0]  len;
    logic [CYC_W-1:0]  cyc_take;
    logic [CYC_W-1:0]  cyc_fall;
  } dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  output dec_t       dec
);
  always_comb begin
    dec          = '0;
    dec.kind     = K_NONE;
    dec.cond     = C_NEV;
    dec.len      = LEN_W'(1);
    dec.cyc_take = '0;
    dec.cyc_fall = '0;
    if (b0[7:4] == 4'hC && b0[3:0] <= 4'hA) begin
      dec.kind     = K_REL;
      dec.disp     = b1;
      dec.len      = LEN_W'(2);
      dec.cyc_take = CYC_W'(3);
      dec.cyc_fall = CYC_W'(1);
      unique case (b0[3:0])
        4'h0:    dec.cond = C_LT;
        4'h1:    dec.cond = C_GT;
        4'h2:    dec.cond = C_GE;
        4'h3:    dec.cond = C_LE;
        4'h4:    dec.cond = C_CS;
        4'h5:    dec.cond = C_HI;
        4'h6:    dec.cond = C_CC;
        4'h7:    dec.cond = C_LS;
        4'h8:    dec.cond = C_EQ;
        4'h9:    dec.cond = C_NE;
        default: dec.cond = C_ALW;
      endcase
    end else if (b0 == 8'hF8 && b1[7:2] == 6'b111010) begin
      dec.kind     = K_REL;
      dec.disp     = b2;
      dec.len      = LEN_W'(3);
      dec.cyc_take = CYC_W'(4);
      dec.cyc_fall = CYC_W'(2);
      unique case (b1[1:0])
        2'd0:    dec.cond = C_VC;
        2'd1:    dec.cond = C_VS;
        2'd2:    dec.cond = C_NC;
        default: dec.cond = C_NS;
      endcase
    end else if (b0[7:1] == 7'b1101100) begin
      dec.kind     = K_LOOP;
      dec.cond     = b0[0] ? C_NE : C_EQ;
      dec.cyc_take = CYC_W'(1);
      dec.cyc_fall = CYC_W'(2);
    end
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  cond_t cond,
  input  logic  z,
  input  logic  n,
  input  logic  c,
  input  logic  v,
  output logic  take
);
  logic lt;
  assign lt = n ^ v;

  always_comb begin
    unique case (cond)
      C_ALW:   take = 1'b1;
      C_EQ:    take = z;
      C_NE:    take = !z;
      C_GT:    take = !(z | lt);
      C_GE:    take = !lt;
      C_LE:    take = z | lt;
      C_LT:    take = lt;
      C_HI:    take = !(c | z);
      C_CC:    take = !c;
      C_LS:    take = c | z;
      C_CS:    take = c;
      C_VC:    take = !v;
      C_VS:    take = v;
      C_NC:    take = !n;
      C_NS:    take = n;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int W        = PC_W,
  parameter int LOOP_OFS = 4
) (
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      lar,
  input  logic [DISP_W-1:0] disp,
  input  logic [LEN_W-1:0]  len,
  input  kind_t             kind,
  input  logic              take,
  output logic [W-1:0]      next_pc
);
  logic [W-1:0] sext, rel_tgt, loop_tgt, fall;

  assign sext     = {{(W-DISP_W){disp[DISP_W-1]}}, disp};
  assign rel_tgt  = pc + sext;
  assign loop_tgt = lar - W'(LOOP_OFS);
  assign fall     = pc + W'(len);

  always_comb begin
    next_pc = fall;
    if (take) begin
      if (kind == K_LOOP) next_pc = loop_tgt;
      else if (kind == K_REL) next_pc = rel_tgt;
    end
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte0,
  input  logic [7:0]       in_byte1,
  input  logic [7:0]       in_byte2,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  loop_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_taken,
  output logic [PC_W-1:0]  out_next_pc,
  output logic [LEN_W-1:0] out_len,
  output logic [CYC_W-1:0] out_cycles,
  output logic             out_not_branch
);
  dec_t            dec;
  logic            take_raw, take;
  logic [PC_W-1:0] npc;

  br_decode u_dec (
    .b0(in_byte0), .b1(in_byte1), .b2(in_byte2), .dec(dec)
  );

  br_cond_eval u_cond (
    .cond(dec.cond), .z(flag_z), .n(flag_n), .c(flag_c), .v(flag_v),
    .take(take_raw)
  );

  assign take = take_raw && (dec.kind != K_NONE);

  br_target #(.W(PC_W), .LOOP_OFS(4)) u_tgt (
    .pc(cur_pc), .lar(loop_addr), .disp(dec.disp), .len(dec.len),
    .kind(dec.kind), .take(take), .next_pc(npc)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next_pc    <= '0;
      out_len        <= '0;
      out_cycles     <= '0;
      out_not_branch <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken      <= take;
        out_next_pc    <= npc;
        out_len        <= dec.len;
        out_cycles     <= take ? dec.cyc_take : dec.cyc_fall;
        out_not_branch <= (dec.kind == K_NONE);
      end
    end
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk
  import br_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_byte0,
  input logic             flag_z,
  input logic [PC_W-1:0]  loop_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_taken,
  input logic [PC_W-1:0]  out_next_pc,
  input logic [LEN_W-1:0] out_len,
  input logic [CYC_W-1:0] out_cycles,
  input logic             out_not_branch
);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !out_valid && !out_taken && out_next_pc == '0 && out_cycles == '0);

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc)
      && $stable(out_taken) && $stable(out_cycles));

  assert_not_branch_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_not_branch |-> !out_taken && out_len == LEN_W'(1));

  assert_loop_target_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_byte0 == 8'hD8 && flag_z |=>
      out_taken && out_next_pc == $past(loop_addr) - PC_W'(4));

  assert_long_cycles_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == LEN_W'(3) |->
      out_cycles == (out_taken ? CYC_W'(4) : CYC_W'(2)));
endmodule

bind br_resolve br_resolve_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte0(in_byte0), .flag_z(flag_z), .loop_addr(loop_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
  .out_next_pc(out_next_pc), .out_len(out_len), .out_cycles(out_cycles),
  .out_not_branch(out_not_branch)
);

// File: tb/br_resolve_bench.sv
module br_resolve_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [7:0]  in_byte0, in_byte1, in_byte2;
  logic        flag_z, flag_n, flag_c, flag_v;
  logic [31:0] cur_pc, loop_addr;
  logic        out_valid, out_ready, out_taken, out_not_branch;
  logic [31:0] out_next_pc;
  logic [1:0]  out_len;
  logic [2:0]  out_cycles;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  br_resolve u_br_resolve (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte0(in_byte0), .in_byte1(in_byte1), .in_byte2(in_byte2),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .cur_pc(cur_pc), .loop_addr(loop_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_taken(out_taken), .out_next_pc(out_next_pc),
    .out_len(out_len), .out_cycles(out_cycles), .out_not_branch(out_not_branch)
  );

  // Result vector: {not_branch, taken, next_pc[31:0], len[1:0], cycles[2:0]}
  function automatic logic [38:0] model(input logic [7:0] b0, b1, b2,
      input logic [3:0] f, input logic [31:0] pc, lar);
    logic z, n, c, v, t, nb;
    logic [7:0] d;
    logic [31:0] npc;
    logic [1:0] ln;
    logic [2:0] cy;
    {z, n, c, v} = f;
    nb = 1'b1; t = 1'b0; ln = 2'd1; cy = 3'd0; d = 8'd0; npc = pc + 32'd1;
    if (b0[7:4] == 4'hC && b0[3:0] <= 4'hA) begin
      nb = 1'b0; ln = 2'd2; d = b1;
      case (b0[3:0])
        4'h0: t = n ^ v;
        4'h1: t = !(z | (n ^ v));
        4'h2: t = !(n ^ v);
        4'h3: t = z | (n ^ v);
        4'h4: t = c;
        4'h5: t = !(c | z);
        4'h6: t = !c;
        4'h7: t = c | z;
        4'h8: t = z;
        4'h9: t = !z;
        default: t = 1'b1;
      endcase
      cy = t ? 3'd3 : 3'd1;
      npc = t ? pc + {{24{d[7]}}, d} : pc + 32'd2;
    end else if (b0 == 8'hF8 && b1 >= 8'hE8 && b1 <= 8'hEB) begin
      nb = 1'b0; ln = 2'd3; d = b2;
      case (b1)
        8'hE8: t = !v;
        8'hE9: t = v;
        8'hEA: t = !n;
        default: t = n;
      endcase
      cy = t ? 3'd4 : 3'd2;
      npc = t ? pc + {{24{d[7]}}, d} : pc + 32'd3;
    end else if (b0 == 8'hD8 || b0 == 8'hD9) begin
      nb = 1'b0;
      t = (b0 == 8'hD8) ? z : !z;
      cy = t ? 3'd1 : 3'd2;
      npc = t ? lar - 32'd4 : pc + 32'd1;
    end
    return {nb, t, npc, ln, cy};
  endfunction

  task automatic check(input string req, input logic [38:0] exp);
    logic [38:0] act;
    act = {out_not_branch, out_taken, out_next_pc, out_len, out_cycles};
    checks++;
    if (!out_valid || act !== exp) begin
      fails++;
      $display("FAIL %s: valid=%b act=%h exp=%h", req, out_valid, act, exp);
    end
  endtask

  // Drive one request at a falling edge, then sample after the next rising edge.
  task automatic send(input logic [7:0] b0, b1, b2, input logic [3:0] f,
      input logic [31:0] pc, lar);
    @(negedge clk);
    in_byte0 = b0; in_byte1 = b1; in_byte2 = b2;
    {flag_z, flag_n, flag_c, flag_v} = f;
    cur_pc = pc; loop_addr = lar; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string req, input logic [7:0] b0, b1, b2,
      input logic [3:0] f, input logic [31:0] pc, lar);
    send(b0, b1, b2, f, pc, lar);
    check(req, model(b0, b1, b2, f, pc, lar));
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_next_pc !== 32'd0 ||
        out_len !== 2'd0 || out_cycles !== 3'd0 || out_not_branch !== 1'b0) begin
      fails++;
      $display("FAIL R10: act=%b%b%h%h%h%b exp=all zero", out_valid, out_taken,
               out_next_pc, out_len, out_cycles, out_not_branch);
    end
  endtask

  task automatic t_short();  // R1 R3 R4 R7
    for (int cc = 0; cc < 10; cc++)
      for (int f = 0; f < 16; f++)
        run("R1", 8'hC0 | 8'(cc), (f[0] ? 8'h90 : 8'h12), 8'h00, 4'(f),
            32'h0000_4000 + 32'(cc), 32'h0);
  endtask

  task automatic t_long();  // R2 R3 R4 R7
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 16; f++)
        run("R2", 8'hF8, 8'hE8 + 8'(k), (f[1] ? 8'hF0 : 8'h7F), 4'(f),
            32'h1234_5670, 32'h0);
  endtask

  task automatic t_always();  // R5
    for (int f = 0; f < 16; f++)
      run("R5", 8'hCA, 8'h80, 8'h00, 4'(f), 32'h0000_0200, 32'h0);
  endtask

  task automatic t_loop();  // R6
    run("R6", 8'hD8, 8'h00, 8'h00, 4'b1000, 32'h100, 32'h800);
    run("R6", 8'hD8, 8'h00, 8'h00, 4'b0111, 32'h100, 32'h800);
    run("R6", 8'hD9, 8'h00, 8'h00, 4'b0000, 32'h100, 32'h800);
    run("R6", 8'hD9, 8'h00, 8'h00, 4'b1000, 32'h100, 32'h800);
    run("R6", 8'hD9, 8'h00, 8'h00, 4'b0000, 32'h100, 32'h2);
  endtask

  task automatic t_wrap();  // R3 R4
    run("R3", 8'hCA, 8'h05, 8'h00, 4'b0000, 32'hFFFF_FFFE, 32'h0);
    run("R3", 8'hCA, 8'hFF, 8'h00, 4'b0000, 32'h0000_0000, 32'h0);
    run("R4", 8'hF8, 8'hE9, 8'h10, 4'b0000, 32'hFFFF_FFFE, 32'h0);
  endtask

  task automatic t_invalid();  // R8
    run("R8", 8'hCB, 8'h10, 8'h00, 4'b1111, 32'h300, 32'h0);
    run("R8", 8'hCF, 8'h10, 8'h00, 4'b1111, 32'h300, 32'h0);
    run("R8", 8'hF8, 8'hEC, 8'h10, 4'b1111, 32'h300, 32'h0);
    run("R8", 8'hF8, 8'h00, 8'h10, 4'b0000, 32'h300, 32'h0);
    run("R8", 8'hD7, 8'h00, 8'h00, 4'b1000, 32'hFFFF_FFFF, 32'h0);
    run("R8", 8'h00, 8'h00, 8'h00, 4'b0000, 32'h300, 32'h0);
  endtask

  task automatic t_backpressure();  // R9
    logic [38:0] ea, eb;
    ea = model(8'hC8, 8'h20, 8'h00, 4'b1000, 32'h500, 32'h0);
    eb = model(8'hC9, 8'h20, 8'h00, 4'b1000, 32'h600, 32'h0);
    @(negedge clk);
    out_ready = 1'b0;
    send(8'hC8, 8'h20, 8'h00, 4'b1000, 32'h500, 32'h0);
    check("R9 first", ea);
    @(negedge clk);
    in_byte0 = 8'hC9; cur_pc = 32'h600; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (in_ready !== 1'b0) begin
        fails++;
        $display("FAIL R9: in_ready act=%b exp=0", in_ready);
      end
      @(posedge clk);
      @(negedge clk);
      check("R9 hold", ea);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 release", eb);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: out_valid act=%b exp=0", out_valid);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_byte0 = 8'h0; in_byte1 = 8'h0; in_byte2 = 8'h0;
    {flag_z, flag_n, flag_c, flag_v} = 4'b0;
    cur_pc = 32'h0; loop_addr = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_short();
    t_long();
    t_always();
    t_loop();
    t_wrap();
    t_invalid();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule